// File: doc/BRIEF.md
# Three-Port Packet Router

The router takes packets one byte per clock on an 8-bit input and sends each one to one of three output channels. A valid strobe frames each packet. The first byte is a header. Its two low bits pick the destination channel, and its upper six bits carry the payload length. Framing follows the strobe rather than the length field. Every byte taken while the strobe is high is the header or a payload byte. The first byte presented after the strobe drops is the parity byte, and it closes the packet.

Each channel has its own 16-byte FIFO. The FIFO stores the complete packet: header, payload and parity. A channel shows its oldest byte on its data output and raises its valid flag while it holds anything. It gives up one byte per clock while its read enable is high.

The router XORs the header and payload bytes together and compares the result with the parity byte. On a mismatch it pulses an error flag. A header that names channel 3 does not match any output, so that packet is consumed and discarded, and the error flag pulses. When the destination FIFO is full, a suspend output tells the sender to hold the current byte until space frees.

Top module: `pkt_router`

## Requirements
- R1: Header bits [1:0] select the channel (0, 1 or 2). The header, every payload byte and the parity byte are written into that channel's FIFO in arrival order.
- R2: A packet starts when in_valid is high while the router is idle, and that same cycle carries the header. Each further byte taken with in_valid high is payload. The first byte taken with in_valid low is the parity byte and ends the packet. A packet with zero payload bytes is legal.
- R3: After the parity byte is taken, err is high for exactly one cycle if the parity byte differs from the XOR of the header and all payload bytes. Otherwise err stays low.
- R4: A header with address 3 writes nothing into any FIFO. All bytes up to and including the first byte with in_valid low are consumed, and err is high for one cycle after that byte.
- R5: suspend is high in the same cycle whenever the byte on offer (a header with in_valid high, or any byte of a packet in progress) is bound for a full FIFO. While suspend is high that byte is not taken, and it is taken in the first cycle suspend is low.
- R6: out_vld[n] is high exactly when FIFO n holds data, and out_data[8n+7:8n] shows its oldest byte. rd_en[n] removes one byte per clock while out_vld[n] is high. rd_en[n] has no effect on an empty FIFO.
- R7: Each FIFO takes exactly 16 bytes before it raises suspend. A byte is never written into a full FIFO.
- R8: While rst_n is low, all FIFOs are empty, the input sequencer is idle, and out_vld, err and suspend are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_data | input | 8 | Byte-serial packet input |
| in_valid | input | 1 | Packet framing strobe |
| suspend | output | 1 | Hold the current byte: the destination FIFO is full |
| err | output | 1 | One-cycle pulse for a bad parity byte or an address-3 packet |
| rd_en | input | 3 | Per-channel pop request |
| out_vld | output | 3 | Per-channel data available |
| out_data | output | 24 | Per-channel oldest byte, channel n in bits [8n+7:8n] |

## Verification
A wrong destination register or a wrong sequencer state shows up on the next clock as a byte on the wrong channel's valid flag or data output. A wrong running XOR stays hidden until the packet ends, and then appears as a missing or extra err pulse in the cycle after the parity byte. A wrong FIFO count or pointer shows up as a wrong data byte at the next pop, or as suspend rising one byte early or late on a full channel. The bench reads out every channel on every cycle and compares err and suspend combinationally, so each of these faults is reported within one clock of reaching a port.

// File: rtl/pr_pkg.sv
package pr_pkg;
  localparam int ADDR_W   = 2;
  localparam int LEN_LSB  = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BODY = 2'd1,
    ST_DROP = 2'd2
  } ing_state_e;
endpackage

// File: rtl/pr_fifo.sv
module pr_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0]  rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              push, pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_FULL);
  assign push    = wr_en && !full;
  assign pop     = rd_en && !empty;
  assign rd_data = mem[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push) begin
      wr_ptr_d = (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
    end
    if (pop) begin
      rd_ptr_d = (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
    end
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mem[wr_ptr_q] <= wr_data;
    end
  end
endmodule

// File: rtl/pr_ingress.sv
module pr_ingress #(
  parameter int DATA_W = 8,
  parameter int NUM_CH = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DATA_W-1:0]   in_data,
  input  logic                in_valid,
  input  logic [NUM_CH-1:0]   ch_full,
  output logic [NUM_CH-1:0]   wr_en,
  output logic [DATA_W-1:0]   wr_data,
  output logic                suspend,
  output logic                err,
  output pr_pkg::ing_state_e  state
);
  import pr_pkg::*;
  localparam int NSLOT = 1 << ADDR_W;

  ing_state_e        state_q, state_d;
  logic [ADDR_W-1:0] dest_q, dest_d, dest_sel;
  logic [DATA_W-1:0] acc_q, acc_d;
  logic              err_q, err_d;
  logic [NSLOT-1:0]  full_pad;
  logic              is_hdr, busy, dest_ok, take, par_bad;

  assign full_pad = NSLOT'(ch_full);
  assign is_hdr   = (state_q == ST_IDLE) && in_valid;
  assign dest_sel = is_hdr ? in_data[ADDR_W-1:0] : dest_q;
  assign dest_ok  = int'(dest_sel) < NUM_CH;
  assign busy     = is_hdr || (state_q == ST_BODY);
  assign suspend  = busy && dest_ok && full_pad[dest_sel];
  assign take     = busy && !suspend;
  assign par_bad  = (acc_q ^ in_data) != '0;
  assign wr_data  = in_data;
  assign err      = err_q;
  assign state    = state_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_wr
    assign wr_en[i] = take && dest_ok && (dest_sel == ADDR_W'(i));
  end

  always_comb begin
    state_d = state_q;
    dest_d  = dest_q;
    acc_d   = acc_q;
    err_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (is_hdr) begin
          dest_d = in_data[ADDR_W-1:0];
          if (!dest_ok) begin
            state_d = ST_DROP;
          end else if (take) begin
            acc_d   = in_data;
            state_d = ST_BODY;
          end
        end
      end
      ST_BODY: begin
        if (take) begin
          if (in_valid) begin
            acc_d = acc_q ^ in_data;
          end else begin
            err_d   = par_bad;
            state_d = ST_IDLE;
          end
        end
      end
      ST_DROP: begin
        if (!in_valid) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dest_q  <= '0;
      acc_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      dest_q  <= dest_d;
      acc_q   <= acc_d;
      err_q   <= err_d;
    end
  end
endmodule

// File: rtl/pkt_router.sv
module pkt_router #(
  parameter int DATA_W = 8,
  parameter int NUM_CH = 3,
  parameter int DEPTH  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DATA_W-1:0]        in_data,
  input  logic                     in_valid,
  output logic                     suspend,
  output logic                     err,
  input  logic [NUM_CH-1:0]        rd_en,
  output logic [NUM_CH-1:0]        out_vld,
  output logic [NUM_CH*DATA_W-1:0] out_data
);
  logic [NUM_CH-1:0]  wr_en;
  logic [NUM_CH-1:0]  ch_full;
  logic [NUM_CH-1:0]  ch_empty;
  logic [DATA_W-1:0]  wr_data;
  pr_pkg::ing_state_e ing_state;

  pr_ingress #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_ingress (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_data  (in_data),
    .in_valid (in_valid),
    .ch_full  (ch_full),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .suspend  (suspend),
    .err      (err),
    .state    (ing_state)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pr_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en[i]),
      .wr_data (wr_data),
      .rd_en   (rd_en[i]),
      .rd_data (out_data[i*DATA_W +: DATA_W]),
      .empty   (ch_empty[i]),
      .full    (ch_full[i])
    );
    assign out_vld[i] = !ch_empty[i];
  end
endmodule

// File: rtl/pr_checks.sv
module pr_checks #(
  parameter int NUM_CH = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              err,
  input logic              suspend,
  input logic [NUM_CH-1:0] rd_en,
  input logic [NUM_CH-1:0] out_vld,
  input logic [NUM_CH-1:0] wr_en,
  input logic [NUM_CH-1:0] ch_full,
  input logic [1:0]        ing_state
);
  // R3: err is a single-cycle pulse
  p_err_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  // R5: backpressure only while a packet is on offer or in progress
  p_suspend_in_pkt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |-> (in_valid || ing_state != 2'd0));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    // R7: never write into a full FIFO
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[i] |-> !ch_full[i]);
    // R6: a written byte makes the channel valid
    p_vld_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[i] |=> out_vld[i]);
    // R6: a channel only empties through a read
    p_empty_by_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_vld[i]) |-> $past(rd_en[i]));
    // R4: dropped packets reach no FIFO
    p_drop_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ing_state == 2'd2) |-> !wr_en[i]);
  end
endmodule

bind pkt_router pr_checks #(.NUM_CH(NUM_CH)) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .err       (err),
  .suspend   (suspend),
  .rd_en     (rd_en),
  .out_vld   (out_vld),
  .wr_en     (wr_en),
  .ch_full   (ch_full),
  .ing_state (ing_state)
);

// File: tb/pkt_router_tb.sv
module pkt_router_tb;
  localparam int NCH = 3;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0;
  logic [NCH-1:0] rd_en = '0;
  logic suspend, err;
  logic [NCH-1:0] out_vld;
  logic [NCH*8-1:0] out_data;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [NCH-1:0] rd_mask = '0;
  bit rd_all = 0;
  int acc_bytes = 0, first_stall = -1, err_seen = 0;

  // reference model state
  int m_state = 0, m_dest = 0;
  logic [7:0] m_acc = '0;
  bit m_err = 0;
  logic [7:0] q0[$], q1[$], q2[$];

  always #2 clk = ~clk;

  pkt_router #(.DATA_W(8), .NUM_CH(NCH), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .suspend(suspend), .err(err), .rd_en(rd_en), .out_vld(out_vld),
    .out_data(out_data)
  );

  function automatic int qsize(int c);
    return (c == 0) ? q0.size() : (c == 1) ? q1.size() : q2.size();
  endfunction
  function automatic logic [7:0] qhead(int c);
    return (c == 0) ? q0[0] : (c == 1) ? q1[0] : q2[0];
  endfunction
  function automatic bit m_busy();
    return (m_state == 1) || (m_state == 0 && in_valid);
  endfunction
  function automatic int m_dsel();
    return (m_state == 0) ? int'(in_data[1:0]) : m_dest;
  endfunction
  function automatic bit m_susp();
    return m_busy() && m_dsel() < NCH && qsize(m_dsel()) >= DEPTH;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // reference model update
  always @(posedge clk) begin
    if (!rst_n) begin
      q0.delete(); q1.delete(); q2.delete();
      m_state = 0; m_dest = 0; m_acc = '0; m_err = 0;
    end else begin
      bit s, e_n;
      bit [NCH-1:0] pop;
      int d;
      for (int i = 0; i < NCH; i++) pop[i] = (rd_en[i] === 1'b1) && qsize(i) > 0;
      s = m_susp(); d = m_dsel(); e_n = 0;
      case (m_state)
        0: if (in_valid && !s) begin
             if (d < NCH) begin
               if (d == 0) q0.push_back(in_data);
               else if (d == 1) q1.push_back(in_data);
               else q2.push_back(in_data);
               m_acc = in_data; m_dest = d; m_state = 1;
             end else m_state = 2;
           end
        1: if (!s) begin
             if (d == 0) q0.push_back(in_data);
             else if (d == 1) q1.push_back(in_data);
             else q2.push_back(in_data);
             if (in_valid) m_acc = m_acc ^ in_data;
             else begin e_n = (m_acc ^ in_data) != 0; m_state = 0; end
           end
        default: if (!in_valid) begin e_n = 1; m_state = 0; end
      endcase
      if (pop[0]) void'(q0.pop_front());
      if (pop[1]) void'(q1.pop_front());
      if (pop[2]) void'(q2.pop_front());
      m_err = e_n;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        chk(out_vld[i] == (qsize(i) > 0), "R6 vld", out_vld[i], qsize(i) > 0);
        if (qsize(i) > 0)
          chk(out_data[i*8 +: 8] == qhead(i), "R1 R6 data", out_data[i*8 +: 8], qhead(i));
      end
      chk(err == m_err, "R3 R4 err", err, m_err);
      chk(suspend == m_susp(), "R5 R7 suspend", suspend, m_susp());
      if (err) err_seen++;
    end
  end

  // read-enable driver
  always @(posedge clk) begin
    #1;
    rd_en = rd_all ? rd_mask : (rd_mask & NCH'($urandom()));
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 0);
      summary();
    end
  end

  task automatic put_byte(bit v, logic [7:0] d);
    in_valid = v; in_data = d;
    @(negedge clk);
    while (suspend) begin
      if (first_stall < 0) first_stall = acc_bytes;
      @(negedge clk);
    end
    acc_bytes++;
    @(posedge clk); #1;
  endtask

  task automatic send_pkt(int addr, int len, bit corrupt);
    logic [7:0] b, par;
    b = {6'(len), 2'(addr)};
    par = b;
    put_byte(1, b);
    for (int k = 0; k < len; k++) begin
      b = 8'($urandom());
      par ^= b;
      put_byte(1, b);
    end
    if (corrupt) par ^= 8'h5A;
    put_byte(0, par);
    in_data = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    int e0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state at the ports
    chk(out_vld == '0 && !err && !suspend, "R8 reset", {out_vld, err, suspend}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 R2: header 0x09 -> channel 1, payload 01 02, parity 0A
    put_byte(1, 8'h09); put_byte(1, 8'h01); put_byte(1, 8'h02); put_byte(0, 8'h0A);
    idle(2);
    @(negedge clk);
    chk(out_vld == 3'b010, "R1 channel", out_vld, 3'b010);
    chk(out_data[15:8] == 8'h09 && !err, "R1 R3 header first", out_data[15:8], 8'h09);
    rd_mask = 3'b010; rd_all = 1; idle(6); rd_mask = '0; rd_all = 0; idle(2);
    @(negedge clk);
    chk(out_vld == '0, "R6 drained", out_vld, 0);

    // R2 R6: mixed traffic with random reads, including zero-length packets
    rd_mask = '1;
    for (int p = 0; p < 30; p++) send_pkt(p % 3, (p * 7) % 11, 0);
    for (int p = 0; p < 6; p++) send_pkt(p % 3, 0, 0);

    // R3: bad parity pulses err
    e0 = err_seen;
    send_pkt(0, 3, 1); idle(3);
    send_pkt(2, 0, 1); idle(3);
    send_pkt(1, 5, 0); idle(3);
    chk(err_seen - e0 == 2, "R3 err count", err_seen - e0, 2);

    // R4: address 3 is dropped, err once per packet, no FIFO touched
    rd_mask = '0; idle(4);
    rd_mask = '1; rd_all = 1; idle(40); rd_mask = '0; rd_all = 0; idle(2);
    e0 = err_seen;
    send_pkt(3, 4, 0); send_pkt(3, 0, 0); idle(3);
    @(negedge clk);
    chk(out_vld == '0, "R4 nothing stored", out_vld, 0);
    chk(err_seen - e0 == 2, "R4 err count", err_seen - e0, 2);

    // R5 R7: fill channel 2 with reads off, then release
    idle(1);
    acc_bytes = 0; first_stall = -1;
    fork
      send_pkt(2, 20, 0);
      begin idle(40); rd_mask = 3'b100; end
    join
    chk(first_stall == DEPTH, "R7 depth", first_stall, DEPTH);

    // R5: back-to-back traffic into congested channels
    rd_mask = 3'b011;
    for (int p = 0; p < 20; p++) send_pkt(p % 2, 12 + p % 5, p % 4 == 0);
    rd_mask = '1; rd_all = 1; idle(80);
    @(negedge clk);
    chk(out_vld == '0 && !suspend, "R6 final drain", out_vld, 0);
    summary();
  end
endmodule